// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block turns one host request into one timed access on a raw NAND flash bus. A request is a command byte, an address byte, or a data transfer (read or write). The block drives chip enable, the command latch and address latch strobes, the write and read strobes, the data bus output enable and the outgoing data. It also captures incoming read data. Each access passes through a setup phase, a strobe phase and a hold phase. A separate hi-Z count decides when write data starts to be driven onto the bus.

Two timing words are held in configuration registers. One serves data transfers and the other serves command and address bytes. A data read that directly follows a command byte or an address byte is held off by a programmable turnaround gap first. An external busy line can stretch the strobe phase when that feature is enabled. A one-cycle done pulse marks the final hold cycle, and the next request can be taken on the cycle after it.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset the outputs are idle: nce, nwe and nre are 1, cle, ale, dq_oe and done are 0, and dq_out and rd_data are 0. Both timing words hold 0x0A in every byte field, the two turnaround fields hold 0xF, the strobe-stretch enable is 0, the width field is 0 and both enables are 0.
- R2: A request is taken only while both enable bits are 1 (config address 3, bit 0 global, bit 1 bank). Otherwise req_ready stays 0 and req_valid has no effect on the bus.
- R3: Config address 0 holds the data-transfer timing word and address 1 holds the command/address timing word. Each word packs setup in bits 7:0, strobe length in 15:8, hold in 23:16 and hi-Z in 31:24. req_kind 0 is a command byte, 1 is an address byte, and 2 or 3 is a data transfer.
- R4: Setup, strobe and hold each last their count in clock cycles, with a count of 0 acting as 1. nce is low from the first setup cycle to the last hold cycle. cle (command) or ale (address) is high over that same span.
- R5: The write strobe nwe (command, address and data writes) or the read strobe nre (data reads) is low only during the strobe phase, and the two strobes are never low together.
- R6: On writes, dq_oe is high from the cycle that lies hi-Z+1 cycles after the first setup cycle until the last hold cycle. On reads it stays 0.
- R7: When the stretch enable (config address 2, bit 2) is 1, a low nwait in the final strobe cycle extends the strobe phase one cycle at a time. When the enable is 0, nwait is ignored.
- R8: Read data is captured from dq_in at the clock edge that ends the last strobe cycle, and it is held on rd_data.
- R9: The width field (config address 2, bits 5:4) selects 16-bit data transfers at value 1 and 8-bit transfers at any other value. In 8-bit mode, and always for command and address bytes, the upper byte of dq_out and rd_data is 0.
- R10: A data read that directly follows a command byte waits (CLE-to-read field + 1) cycles before setup. One that follows an address byte waits (ALE-to-read field + 1) cycles. The fields sit at config address 2, bits 11:8 and 15:12. A read that follows a data transfer does not wait.
- R11: done is high for exactly the last hold cycle, and req_ready returns to 1 on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select (0 data timing, 1 cmd/addr timing, 2 control, 3 enables) |
| cfg_wdata | input | 32 | Configuration write value |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 0 command, 1 address, 2/3 data |
| req_write | input | 1 | Data direction for data transfers (1 write) |
| req_wdata | input | 16 | Command, address or write data |
| req_ready | output | 1 | Request is taken at the next edge when valid |
| nce | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| nwe | output | 1 | Write strobe, active low |
| nre | output | 1 | Read strobe, active low |
| dq_oe | output | 1 | Data bus output enable |
| dq_out | output | 16 | Outgoing bus value |
| dq_in | input | 16 | Incoming bus value |
| nwait | input | 1 | Busy line, low stretches the strobe |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | Last hold cycle of an access |

## Verification
The assertions check properties that must hold on every cycle. The strobes are mutually exclusive and stay inside chip enable. cle and ale are never high together, and the output enable is only raised under chip enable with the read strobe off. done never lasts two cycles. A low nwait in the final strobe cycle keeps the phase when stretching is enabled, the turnaround gap appears only ahead of reads, and a disabled block stays idle. The phase lengths, the hi-Z offset, the choice of timing word, the gap lengths, the capture cycle and the width masking depend on programmed counts. Only the bench scenarios can show those. They sweep the counts and compare each edge position against arithmetic expectations.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  localparam int TF_W    = 8;
  localparam int DL_W    = 4;
  localparam int DQ_W    = 16;
  localparam int CFG_W   = 4 * TF_W;
  localparam int SINCE_W = TF_W + 1;
  localparam int NBANK   = 2;

  localparam logic [TF_W-1:0] TF_RESET = 8'h0A;
  localparam logic [DL_W-1:0] DL_RESET = 4'hF;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_DATA = 2'd2,
    K_DATB = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GAP,
    PH_SETUP,
    PH_WAIT,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic [TF_W-1:0] hiz;
    logic [TF_W-1:0] hold;
    logic [TF_W-1:0] strobe;
    logic [TF_W-1:0] setup;
  } tim_t;

  function automatic logic [TF_W-1:0] min_one(input logic [TF_W-1:0] v);
    return (v == '0) ? TF_W'(1) : v;
  endfunction

  function automatic tim_t clamp_tim(input tim_t t);
    tim_t r;
    r        = t;
    r.setup  = min_one(t.setup);
    r.strobe = min_one(t.strobe);
    r.hold   = min_one(t.hold);
    return r;
  endfunction

endpackage

// File: rtl/nseq_cfg.sv
module nseq_cfg
  import nseq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_addr,
  input  logic [CFG_W-1:0]            cfg_wdata,
  output logic [NBANK-1:0][CFG_W-1:0] bank_words,
  output logic                        wait_en,
  output logic                        wide,
  output logic [DL_W-1:0]             cle_dly,
  output logic [DL_W-1:0]             ale_dly,
  output logic                        glb_en,
  output logic                        bnk_en
);

  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_EN   = 2'd3;

  logic [1:0] width_q;

  // one timing word per bank, selected by its own index
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank_words[b] <= {4{TF_RESET}};
      else if (cfg_we && cfg_addr == 2'(b))
        bank_words[b] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_en <= 1'b0;
      width_q <= 2'd0;
      cle_dly <= DL_RESET;
      ale_dly <= DL_RESET;
      glb_en  <= 1'b0;
      bnk_en  <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_CTRL) begin
        wait_en <= cfg_wdata[2];
        width_q <= cfg_wdata[5:4];
        cle_dly <= cfg_wdata[11:8];
        ale_dly <= cfg_wdata[15:12];
      end
      if (cfg_addr == ADDR_EN) begin
        glb_en <= cfg_wdata[0];
        bnk_en <= cfg_wdata[1];
      end
    end
  end

  assign wide = (width_q == 2'd1);

endmodule

// File: rtl/nseq_fsm.sv
module nseq_fsm
  import nseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_en,
  input  logic               bnk_en,
  input  logic               wait_en,
  input  logic               wide_cfg,
  input  logic [DL_W-1:0]    cle_dly,
  input  logic [DL_W-1:0]    ale_dly,
  input  logic [CFG_W-1:0]   mem_word,
  input  logic [CFG_W-1:0]   att_word,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic               req_write,
  input  logic               nwait,
  output logic               req_ready,
  output logic               accept,
  output logic               sample,
  output phase_e             phase_n,
  output kind_e              kind_n,
  output logic               write_n,
  output logic               wide_n,
  output tim_t               tim_n,
  output logic [TF_W-1:0]    cnt_n,
  output logic [SINCE_W-1:0] since_n
);

  localparam logic [SINCE_W-1:0] SINCE_MAX = '1;

  phase_e             phase_q;
  kind_e              kind_q, last_q, last_n;
  logic               write_q, wide_q;
  tim_t               tim_q;
  logic [TF_W-1:0]    cnt_q;
  logic [SINCE_W-1:0] since_q, since_inc;
  logic [DL_W-1:0]    gap_q, gap_n;
  logic               en_ok, req_data, need_gap, stall;

  assign en_ok     = glb_en & bnk_en;
  assign req_ready = (phase_q == PH_IDLE) && en_ok;
  assign req_data  = req_kind[1];
  assign need_gap  = req_data && !req_write && (last_q == K_CMD || last_q == K_ADDR);
  assign since_inc = (since_q == SINCE_MAX) ? since_q : since_q + 1'b1;
  assign stall     = wait_en && !nwait;

  always_comb begin
    phase_n = phase_q;
    kind_n  = kind_q;
    write_n = write_q;
    wide_n  = wide_q;
    tim_n   = tim_q;
    cnt_n   = cnt_q;
    since_n = since_q;
    gap_n   = gap_q;
    last_n  = last_q;
    accept  = 1'b0;
    sample  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid && en_ok) begin
          accept  = 1'b1;
          kind_n  = kind_e'(req_kind);
          write_n = req_data ? req_write : 1'b1;
          wide_n  = req_data & wide_cfg;
          tim_n   = clamp_tim(req_data ? mem_word : att_word);
          cnt_n   = '0;
          since_n = '0;
          gap_n   = (last_q == K_CMD) ? cle_dly : ale_dly;
          phase_n = need_gap ? PH_GAP : PH_SETUP;
        end
      end
      PH_GAP: begin
        if (cnt_q == TF_W'(gap_q)) begin
          phase_n = PH_SETUP;
          cnt_n   = '0;
          since_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_SETUP: begin
        since_n = since_inc;
        if (cnt_q == tim_q.setup - 1'b1) begin
          phase_n = PH_WAIT;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_WAIT: begin
        since_n = since_inc;
        if (cnt_q == tim_q.strobe - 1'b1) begin
          if (!stall) begin
            sample  = 1'b1;
            phase_n = PH_HOLD;
            cnt_n   = '0;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_HOLD: begin
        since_n = since_inc;
        if (cnt_q == tim_q.hold - 1'b1) begin
          phase_n = PH_IDLE;
          last_n  = kind_q;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      kind_q  <= K_DATA;
      last_q  <= K_DATA;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      tim_q   <= '0;
      cnt_q   <= '0;
      since_q <= '0;
      gap_q   <= '0;
    end else begin
      phase_q <= phase_n;
      kind_q  <= kind_n;
      last_q  <= last_n;
      write_q <= write_n;
      wide_q  <= wide_n;
      tim_q   <= tim_n;
      cnt_q   <= cnt_n;
      since_q <= since_n;
      gap_q   <= gap_n;
    end
  end

  // R7: a busy line seen in the last strobe cycle keeps the strobe phase
  p_stretch_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WAIT && cnt_q == tim_q.strobe - 1'b1 && wait_en && !nwait)
      |=> (phase_q == PH_WAIT));

  // R10: the turnaround gap precedes data reads only
  p_gap_reads_only_r10: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_GAP) |-> (kind_q[1] && !write_q));

  // R2: a disabled block stays idle
  p_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !(glb_en && bnk_en)) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/nseq_pins.sv
module nseq_pins
  import nseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  phase_e             phase_n,
  input  kind_e              kind_n,
  input  logic               write_n,
  input  logic               wide_n,
  input  tim_t               tim_n,
  input  logic [TF_W-1:0]    cnt_n,
  input  logic [SINCE_W-1:0] since_n,
  input  logic               accept,
  input  logic               sample,
  input  logic [DQ_W-1:0]    req_wdata,
  input  logic [DQ_W-1:0]    dq_in,
  output logic               nce,
  output logic               cle,
  output logic               ale,
  output logic               nwe,
  output logic               nre,
  output logic               dq_oe,
  output logic [DQ_W-1:0]    dq_out,
  output logic [DQ_W-1:0]    rd_data,
  output logic               done
);

  localparam int NBYTE = DQ_W / 8;

  logic [DQ_W-1:0] lane_mask;
  logic            active_n, strobe_n, oe_due;

  // lane 0 always carries data, upper lanes only in wide transfers
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    if (b == 0) begin : g_low
      assign lane_mask[7:0] = 8'hFF;
    end else begin : g_high
      assign lane_mask[b*8 +: 8] = {8{wide_n}};
    end
  end

  assign active_n = (phase_n == PH_SETUP) || (phase_n == PH_WAIT) || (phase_n == PH_HOLD);
  assign strobe_n = (phase_n == PH_WAIT);
  assign oe_due   = since_n >= ({1'b0, tim_n.hiz} + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      nce     <= 1'b1;
      cle     <= 1'b0;
      ale     <= 1'b0;
      nwe     <= 1'b1;
      nre     <= 1'b1;
      dq_oe   <= 1'b0;
      dq_out  <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      nce   <= !active_n;
      cle   <= active_n && (kind_n == K_CMD);
      ale   <= active_n && (kind_n == K_ADDR);
      nwe   <= !(strobe_n && write_n);
      nre   <= !(strobe_n && !write_n);
      dq_oe <= active_n && write_n && oe_due;
      done  <= (phase_n == PH_HOLD) && (cnt_n == tim_n.hold - 1'b1);
      if (accept)
        dq_out <= req_wdata & lane_mask;
      if (sample)
        rd_data <= dq_in & lane_mask;
    end
  end

  // R5: never both strobes
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !(!nwe && !nre));

  // R5: strobes only inside chip enable
  p_strobe_under_ce_r5: assert property (@(posedge clk) disable iff (rst)
    (!nwe || !nre) |-> !nce);

  // R4: latch enables are exclusive
  p_cle_ale_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));

  // R6: the bus is driven only under chip enable with no read strobe
  p_oe_under_ce_r6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!nce && nre));

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_write,
  input  logic [DQ_W-1:0]  req_wdata,
  output logic             req_ready,
  output logic             nce,
  output logic             cle,
  output logic             ale,
  output logic             nwe,
  output logic             nre,
  output logic             dq_oe,
  output logic [DQ_W-1:0]  dq_out,
  input  logic [DQ_W-1:0]  dq_in,
  input  logic             nwait,
  output logic [DQ_W-1:0]  rd_data,
  output logic             done
);

  logic [NBANK-1:0][CFG_W-1:0] bank_words;
  logic                        wait_en, wide, glb_en, bnk_en;
  logic [DL_W-1:0]             cle_dly, ale_dly;
  logic                        accept, sample, write_n, wide_n;
  phase_e                      phase_n;
  kind_e                       kind_n;
  tim_t                        tim_n;
  logic [TF_W-1:0]             cnt_n;
  logic [SINCE_W-1:0]          since_n;

  nseq_cfg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .bank_words (bank_words),
    .wait_en    (wait_en),
    .wide       (wide),
    .cle_dly    (cle_dly),
    .ale_dly    (ale_dly),
    .glb_en     (glb_en),
    .bnk_en     (bnk_en)
  );

  nseq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .glb_en    (glb_en),
    .bnk_en    (bnk_en),
    .wait_en   (wait_en),
    .wide_cfg  (wide),
    .cle_dly   (cle_dly),
    .ale_dly   (ale_dly),
    .mem_word  (bank_words[0]),
    .att_word  (bank_words[1]),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_write (req_write),
    .nwait     (nwait),
    .req_ready (req_ready),
    .accept    (accept),
    .sample    (sample),
    .phase_n   (phase_n),
    .kind_n    (kind_n),
    .write_n   (write_n),
    .wide_n    (wide_n),
    .tim_n     (tim_n),
    .cnt_n     (cnt_n),
    .since_n   (since_n)
  );

  nseq_pins u_pins (
    .clk       (clk),
    .rst       (rst),
    .phase_n   (phase_n),
    .kind_n    (kind_n),
    .write_n   (write_n),
    .wide_n    (wide_n),
    .tim_n     (tim_n),
    .cnt_n     (cnt_n),
    .since_n   (since_n),
    .accept    (accept),
    .sample    (sample),
    .req_wdata (req_wdata),
    .dq_in     (dq_in),
    .nce       (nce),
    .cle       (cle),
    .ale       (ale),
    .nwe       (nwe),
    .nre       (nre),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .rd_data   (rd_data),
    .done      (done)
  );

endmodule

// File: tb/tb_nand_strobe_seq.sv
`timescale 1ns/1ps
module tb_nand_strobe_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = 16'd0;
  logic        req_ready, nce, cle, ale, nwe, nre, dq_oe, done;
  logic [15:0] dq_out, rd_data;
  logic [15:0] dq_in = 16'd0;
  logic        nwait = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  nand_strobe_seq dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_kind(req_kind), .req_write(req_write), .req_wdata(req_wdata),
    .req_ready(req_ready), .nce(nce), .cle(cle), .ale(ale), .nwe(nwe), .nre(nre),
    .dq_oe(dq_oe), .dq_out(dq_out), .dq_in(dq_in), .nwait(nwait), .rd_data(rd_data),
    .done(done)
  );

  always #10 clk = ~clk;

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input bit wen, input logic [1:0] wd,
                                      input logic [3:0] cdl, input logic [3:0] adl);
    return {16'h0, adl, cdl, 2'b00, wd, 1'b0, wen, 2'b00};
  endfunction

  function automatic logic [31:0] tword(input int s, input int w, input int h, input int z);
    return {8'(z), 8'(h), 8'(w), 8'(s)};
  endfunction

  // one access; timings are raw field values, expectations derived here
  task automatic run_access(input string ctx, input logic [1:0] kind, input bit wr,
                            input logic [15:0] wd, input int pre, input int s_raw,
                            input int w_raw, input int h_raw, input int z, input int x,
                            input int stretch_end, input bit wide);
    int s, w, h, len;
    int first_ce, ce_n, first_stb, stb_n, other_n, cle_n, ale_n;
    int first_oe, oe_n, done_idx, done_n, exp_oe_n;
    logic [15:0] out_seen, mask, exp_rd;
    bit is_wr;
    s = eff(s_raw); w = eff(w_raw); h = eff(h_raw);
    len = s + w + x + h;
    is_wr = kind[1] ? wr : 1'b1;
    mask = (kind[1] && wide) ? 16'hFFFF : 16'h00FF;
    first_ce = -1; ce_n = 0; first_stb = -1; stb_n = 0; other_n = 0;
    cle_n = 0; ale_n = 0; first_oe = -1; oe_n = 0; done_idx = -1; done_n = 0;
    out_seen = 16'h0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_write = wr; req_wdata = wd;
    for (int idx = 0; idx < 3000 && done_idx < 0; idx++) begin
      @(negedge clk);
      req_valid = 1'b0;
      nwait = (idx >= stretch_end);
      dq_in = 16'h1234 + 16'(idx) * 16'h0101;
      if (!nce) begin if (first_ce < 0) first_ce = idx; ce_n++; end
      if (is_wr ? !nwe : !nre) begin
        if (first_stb < 0) begin first_stb = idx; out_seen = dq_out; end
        stb_n++;
      end
      if (is_wr ? !nre : !nwe) other_n++;
      if (cle) cle_n++;
      if (ale) ale_n++;
      if (dq_oe) begin if (first_oe < 0) first_oe = idx; oe_n++; end
      if (done) begin done_idx = idx; done_n++; end
    end
    if (done_idx < 0) chk({ctx, " R11 access never completed"}, 0, 1);
    @(negedge clk);
    nwait = 1'b1;
    exp_rd = (16'h1234 + 16'(pre + s + w + x - 1) * 16'h0101) & mask;
    chk({ctx, " R10 cycles before chip enable"}, first_ce, pre);
    chk({ctx, " R4 chip enable length"}, ce_n, len);
    chk({ctx, " R4 cle span"}, cle_n, (kind == 2'd0) ? len : 0);
    chk({ctx, " R4 ale span"}, ale_n, (kind == 2'd1) ? len : 0);
    chk({ctx, " R5 strobe start"}, first_stb, pre + s);
    chk({ctx, (x > 0) ? " R7 stretched strobe length" : " R3 strobe length"}, stb_n, w + x);
    chk({ctx, " R5 opposite strobe idle"}, other_n, 0);
    exp_oe_n = (is_wr && (z + 1 < len)) ? len - (z + 1) : 0;
    chk({ctx, " R6 output enable cycles"}, oe_n, exp_oe_n);
    if (exp_oe_n > 0) chk({ctx, " R6 output enable start"}, first_oe, pre + z + 1);
    chk({ctx, " R11 done cycle"}, done_idx, pre + len - 1);
    chk({ctx, " R11 done width"}, done_n, 1);
    chk({ctx, " R11 ready after done"}, int'(req_ready), 1);
    if (is_wr) chk({ctx, " R9 write data lanes"}, int'(out_seen), int'(wd & mask));
    else       chk({ctx, " R8 captured read data"}, int'(rd_data), int'(exp_rd));
  endtask

  task automatic blocked(input string ctx);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_write = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk({ctx, " R2 bus idle while disabled"}, int'(nce), 1);
      chk({ctx, " R2 not ready while disabled"}, int'(req_ready), 0);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int sv[3], wv[3], hv[3], zv[3];
    int combo;
    sv = '{0, 1, 3}; wv = '{0, 1, 2}; hv = '{0, 1, 2}; zv = '{0, 1, 4};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle pins after reset
    chk("R1 nce", int'(nce), 1);
    chk("R1 nwe", int'(nwe), 1);
    chk("R1 nre", int'(nre), 1);
    chk("R1 cle/ale", int'({cle, ale}), 0);
    chk("R1 dq_oe", int'(dq_oe), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 dq_out", int'(dq_out), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    // R2: each enable alone is not enough
    blocked("none");
    cfg_write(2'd3, 32'h1);
    blocked("global only");
    cfg_write(2'd3, 32'h2);
    blocked("bank only");
    cfg_write(2'd3, 32'h3);
    // R1: default words 0x0A and turnaround fields 0xF
    run_access("R1 default cmd", 2'd0, 1'b1, 16'hAB70, 0, 10, 10, 10, 10, 0, 0, 0);
    run_access("R1 default read after cmd", 2'd2, 1'b0, 16'h0, 16, 10, 10, 10, 10, 0, 0, 0);
    run_access("R1 default addr", 2'd1, 1'b1, 16'h0055, 0, 10, 10, 10, 10, 0, 0, 0);
    run_access("R1 default read after addr", 2'd2, 1'b0, 16'h0, 16, 10, 10, 10, 10, 0, 0, 0);
    run_access("R1 default write", 2'd2, 1'b1, 16'hBEEF, 0, 10, 10, 10, 10, 0, 0, 0);
    // R3: sweep both timing words independently
    combo = 0;
    for (int si = 0; si < 3; si++)
      for (int wi = 0; wi < 3; wi++)
        for (int hi = 0; hi < 3; hi++)
          for (int zi = 0; zi < 3; zi++) begin
            bit wd;
            int s, w, h, z;
            s = sv[si]; w = wv[wi]; h = hv[hi]; z = zv[zi];
            wd = combo[0];
            combo++;
            cfg_write(2'd2, ctl(1'b0, wd ? 2'd1 : 2'd2, 4'd2, 4'd5));
            cfg_write(2'd1, tword(s, w, h, z));
            cfg_write(2'd0, tword(s + 2, w, h + 1, z + 1));
            run_access("sweep cmd", 2'd0, 1'b1, 16'h9C3A, 0, s, w, h, z, 0, 0, wd);
            run_access("sweep read after cmd", 2'd2, 1'b0, 16'h0, 3, s + 2, w, h + 1, z + 1, 0, 0, wd);
            run_access("sweep addr", 2'd1, 1'b1, 16'h71E4, 0, s, w, h, z, 0, 0, wd);
            run_access("sweep read after addr", 2'd3, 1'b0, 16'h0, 6, s + 2, w, h + 1, z + 1, 0, 0, wd);
            run_access("sweep write", 2'd2, 1'b1, 16'hD00D, 0, s + 2, w, h + 1, z + 1, 0, 0, wd);
            run_access("sweep read after data", 2'd2, 1'b0, 16'h0, 0, s + 2, w, h + 1, z + 1, 0, 0, wd);
          end
    // R7: busy-line stretching
    cfg_write(2'd2, ctl(1'b1, 2'd1, 4'd0, 4'd0));
    cfg_write(2'd0, tword(1, 2, 1, 0));
    cfg_write(2'd1, tword(2, 1, 2, 1));
    run_access("R7 read stretch", 2'd2, 1'b0, 16'h0, 0, 1, 2, 1, 0, 3, 5, 1);
    run_access("R7 write stretch", 2'd2, 1'b1, 16'h4321, 0, 1, 2, 1, 0, 2, 4, 1);
    run_access("R7 cmd stretch", 2'd0, 1'b1, 16'h00E0, 0, 2, 1, 2, 1, 1, 3, 1);
    run_access("R7 read ready line high", 2'd2, 1'b0, 16'h0, 1, 1, 2, 1, 0, 0, 0, 1);
    cfg_write(2'd2, ctl(1'b0, 2'd1, 4'd0, 4'd0));
    run_access("R7 busy ignored when off", 2'd2, 1'b0, 16'h0, 0, 1, 2, 1, 0, 0, 100000, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule